// File: doc/BRIEF.md
# Event Routing Channel

This block is a single lane of a peripheral event fabric. A selector chooses one line out of a vector of event generator outputs. The chosen line is then carried to the channel output over one of three routes. The first is a single-register synchronous capture. The second is a two-register resynchronizer for sources in another clock domain. The third is a combinational pass-through that needs no clock. On the two clocked routes an edge detector turns changes of the chosen line into one-cycle pulses. It can react to rising changes, falling changes, both, or none.

The channel also produces a request for its own clock. The request is either held on while the channel is in use, or raised only while a change is travelling through the clocked logic. When a standby input is active, the clocked routes can be silenced unless the channel is set to keep running. Software sets everything with one 32-bit word written in a single cycle.

Top module: `evt_route_chan`

## Requirements
- R1: After reset the configuration word is 0x00008000: selector 0, synchronous route, edge mode none, keep-running off, on-demand request on. In this state `evt_o` and `clk_req_o` are both 0.
- R2: A write with `cfg_we_i` high loads all fields in one cycle. The generator selector sits in the lowest SEL_W bits (field 6:0), the route in bits 9:8, the edge mode in bits 11:10, keep-running in bit 14 and on-demand in bit 15. All other bits are ignored. Only generator input `gen_i[selector]` can affect the output.
- R3: With selector 0 the channel is off: `evt_o` and `clk_req_o` stay 0 whatever `gen_i` does.
- R4: Route 0 (synchronous) captures the chosen line in one register. A change sampled at clock edge k gives a pulse on `evt_o` that is high for exactly the cycle after edge k+1.
- R5: Route 1 (resynchronized) passes the chosen line through two registers. The same pulse appears one cycle later than on route 0, after edge k+2.
- R6: Edge mode 0 gives no pulses, 1 pulses on rising changes only, 2 on falling changes only, and 3 on both.
- R7: On route 2 (pass-through) `evt_o` equals the chosen generator line combinationally. Edge mode, on-demand and standby have no effect, and `clk_req_o` equals (selector != 0).
- R8: Route 3 is reserved and acts as disabled: `evt_o` and `clk_req_o` stay 0.
- R9: On routes 0 and 1, when `standby_i` is 1 and keep-running is 0, no pulses are produced and `clk_req_o` is 0.
- R10: On routes 0 and 1 with on-demand 0, a non-zero selector and no standby block, `clk_req_o` is held at 1.
- R11: On routes 0 and 1 with on-demand 1, `clk_req_o` rises in the same cycle that the chosen line differs from its captured value. It falls once the capture registers, the edge history and the pulse have all settled.
- R12: A configuration write clears the capture and edge history. No pulse is produced from the old history or from the level the chosen line already has when the write happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word |
| gen_i | input | 2**SEL_W | Event generator lines, index = selector value |
| standby_i | input | 1 | Standby sleep indication |
| evt_o | output | 1 | Channel event output |
| clk_req_o | output | 1 | Request for the channel clock |

## Verification
The bench builds the channel with SEL_W = 3, so there are eight generator lines. This makes a full sweep possible over every non-zero selector, all four route codes, all four edge modes, both request modes and all four standby and keep-running combinations. For each combination it checks the exact cycle of each pulse, the request level while a change is in flight and after it has settled, and that neighbouring lines are ignored. It also checks that a rewrite made while the chosen line is already high stays silent, and it checks selector 0 separately.

// File: rtl/evt_route_pkg.sv
`timescale 1ns/1ps
package evt_route_pkg;

  typedef enum logic [1:0] {
    PATH_SYNC   = 2'd0,
    PATH_RESYNC = 2'd1,
    PATH_ASYNC  = 2'd2,
    PATH_RSVD   = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  // bit positions inside the configuration word
  localparam int CfgSelLsb  = 0;
  localparam int CfgPathLsb = 8;
  localparam int CfgEdgeLsb = 10;
  localparam int CfgStbyBit = 14;
  localparam int CfgOdBit   = 15;

  localparam logic [31:0] CfgResetVal = 32'h0000_8000;

endpackage

// File: rtl/evt_gen_mux.sv
`timescale 1ns/1ps
module evt_gen_mux #(
  parameter int SEL_W = 7,
  localparam int GEN_W = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [GEN_W-1:0] gen_i,
  output logic             line_o
);

  // selector value zero means "no generator"
  always_comb begin
    if (sel_i == '0) begin
      line_o = 1'b0;
    end else begin
      line_o = gen_i[sel_i];
    end
  end

endmodule

// File: rtl/evt_sampler.sv
`timescale 1ns/1ps
module evt_sampler #(
  parameter int STAGES = 2,
  localparam int WARM_MAX = STAGES + 1,
  localparam int WARM_W = $clog2(WARM_MAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic resync_i,
  input  logic din_i,
  output logic sampled_o,
  output logic prev_o,
  output logic settled_o,
  output logic warm_ok_o
);

  logic [STAGES-1:0] stage_q, stage_d;
  logic              prev_q, prev_d;
  logic [WARM_W-1:0] warm_q, warm_d;
  logic [STAGES-1:0] stage_eq;

  // capture chain: stage 0 looks at the raw line, later stages at their neighbour
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stage_d[i]  = clr_i ? 1'b0 : din_i;
      assign stage_eq[i] = (stage_q[i] == din_i);
    end else begin : g_next
      assign stage_d[i]  = clr_i ? 1'b0 : stage_q[i-1];
      assign stage_eq[i] = (stage_q[i] == stage_q[i-1]) | ~resync_i;
    end
  end

  assign sampled_o = resync_i ? stage_q[STAGES-1] : stage_q[0];
  assign prev_o    = prev_q;
  assign settled_o = (&stage_eq) & (prev_q == sampled_o);

  always_comb begin
    prev_d = clr_i ? 1'b0 : sampled_o;
    if (clr_i) begin
      warm_d = '0;
    end else if (warm_q == WARM_W'(WARM_MAX)) begin
      warm_d = warm_q;
    end else begin
      warm_d = warm_q + WARM_W'(1);
    end
  end

  // history is trustworthy only once every register on the route has refilled
  assign warm_ok_o = resync_i ? (warm_q >= WARM_W'(WARM_MAX))
                              : (warm_q >= WARM_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      prev_q  <= 1'b0;
      warm_q  <= '0;
    end else begin
      stage_q <= stage_d;
      prev_q  <= prev_d;
      warm_q  <= warm_d;
    end
  end

endmodule

// File: rtl/evt_edge_det.sv
`timescale 1ns/1ps
module evt_edge_det
  import evt_route_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  en_i,
  input  edge_e mode_i,
  input  logic  cur_i,
  input  logic  prev_i,
  output logic  pulse_o
);

  logic rise, fall, hit;
  logic pulse_q, pulse_d;

  assign rise = cur_i & ~prev_i;
  assign fall = ~cur_i & prev_i;

  always_comb begin
    unique case (mode_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    pulse_d = ~clr_i & en_i & hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/evt_route_chan.sv
`timescale 1ns/1ps
module evt_route_chan
  import evt_route_pkg::*;
#(
  parameter int SEL_W = 7,
  localparam int GEN_W = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic [GEN_W-1:0] gen_i,
  input  logic             standby_i,
  output logic             evt_o,
  output logic             clk_req_o
);

  localparam logic [SEL_W-1:0] SelRst  = CfgResetVal[CfgSelLsb +: SEL_W];
  localparam logic [1:0]       PathRst = CfgResetVal[CfgPathLsb +: 2];
  localparam logic [1:0]       EdgeRst = CfgResetVal[CfgEdgeLsb +: 2];
  localparam logic             StbyRst = CfgResetVal[CfgStbyBit];
  localparam logic             OdRst   = CfgResetVal[CfgOdBit];

  // configuration state
  logic [SEL_W-1:0] sel_q, sel_d;
  path_e            path_q, path_d;
  edge_e            edge_q, edge_d;
  logic             run_stdby_q, run_stdby_d;
  logic             on_demand_q, on_demand_d;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata_i[31:16], cfg_wdata_i[13:12],
                             cfg_wdata_i[7:SEL_W]};

  always_comb begin
    sel_d       = sel_q;
    path_d      = path_q;
    edge_d      = edge_q;
    run_stdby_d = run_stdby_q;
    on_demand_d = on_demand_q;
    if (cfg_we_i) begin
      sel_d       = cfg_wdata_i[CfgSelLsb +: SEL_W];
      path_d      = path_e'(cfg_wdata_i[CfgPathLsb +: 2]);
      edge_d      = edge_e'(cfg_wdata_i[CfgEdgeLsb +: 2]);
      run_stdby_d = cfg_wdata_i[CfgStbyBit];
      on_demand_d = cfg_wdata_i[CfgOdBit];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= SelRst;
      path_q      <= path_e'(PathRst);
      edge_q      <= edge_e'(EdgeRst);
      run_stdby_q <= StbyRst;
      on_demand_q <= OdRst;
    end else begin
      sel_q       <= sel_d;
      path_q      <= path_d;
      edge_q      <= edge_d;
      run_stdby_q <= run_stdby_d;
      on_demand_q <= on_demand_d;
    end
  end

  // datapath
  logic line, sampled, prev, settled, warm_ok, pulse;
  logic chan_on, clocked, gated, det_en;

  evt_gen_mux #(.SEL_W(SEL_W)) mux_i (
    .sel_i  (sel_q),
    .gen_i  (gen_i),
    .line_o (line)
  );

  evt_sampler #(.STAGES(2)) smp_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_we_i),
    .resync_i  (path_q == PATH_RESYNC),
    .din_i     (line),
    .sampled_o (sampled),
    .prev_o    (prev),
    .settled_o (settled),
    .warm_ok_o (warm_ok)
  );

  assign chan_on = (sel_q != '0);
  assign clocked = (path_q == PATH_SYNC) | (path_q == PATH_RESYNC);
  assign gated   = standby_i & ~run_stdby_q;
  assign det_en  = chan_on & clocked & ~gated & warm_ok;

  evt_edge_det edge_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg_we_i),
    .en_i    (det_en),
    .mode_i  (edge_q),
    .cur_i   (sampled),
    .prev_i  (prev),
    .pulse_o (pulse)
  );

  always_comb begin
    unique case (path_q)
      PATH_ASYNC: begin
        evt_o     = line;
        clk_req_o = chan_on;
      end
      PATH_SYNC, PATH_RESYNC: begin
        evt_o     = pulse;
        clk_req_o = chan_on & ~gated & (~on_demand_q | ~settled | pulse);
      end
      default: begin
        evt_o     = 1'b0;
        clk_req_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/evt_route_chan_chk.sv
`timescale 1ns/1ps
module evt_route_chan_chk #(
  parameter int SEL_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic             standby_i,
  input logic             evt_o,
  input logic             clk_req_o,
  input logic [SEL_W-1:0] sel_q,
  input logic [1:0]       path_q,
  input logic [1:0]       edge_q,
  input logic             run_stdby_q,
  input logic             on_demand_q
);

  // R3
  sel_zero_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == '0) |-> (!evt_o && !clk_req_o));

  // R8
  rsvd_path_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (path_q == 2'd3) |-> (!evt_o && !clk_req_o));

  // R9
  stby_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && standby_i && !run_stdby_q && !path_q[1]) |=> !evt_o);

  // R12
  write_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> ((path_q == 2'd2) || !evt_o));

  // R6
  edge_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!path_q[1] && edge_q == 2'd0) |-> !evt_o);

  // R11
  od_req_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_demand_q && !path_q[1] && evt_o && !(standby_i && !run_stdby_q))
      |-> clk_req_o);

endmodule

bind evt_route_chan evt_route_chan_chk #(.SEL_W(SEL_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .standby_i   (standby_i),
  .evt_o       (evt_o),
  .clk_req_o   (clk_req_o),
  .sel_q       (sel_q),
  .path_q      (path_q),
  .edge_q      (edge_q),
  .run_stdby_q (run_stdby_q),
  .on_demand_q (on_demand_q)
);

// File: tb/evt_route_chan_tb_top.sv
`timescale 1ns/1ps
module evt_route_chan_tb_top;

  localparam int SW = 3;
  localparam int GW = 1 << SW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [GW-1:0] gen = '0;
  logic          stby = 1'b0;
  logic          evt, req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_route_chan #(.SEL_W(SW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (we),
    .cfg_wdata_i (wdata),
    .gen_i       (gen),
    .standby_i   (stby),
    .evt_o       (evt),
    .clk_req_o   (req)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [31:0] w);
    we = 1'b1;
    wdata = w;
    step();
    we = 1'b0;
    wdata = 32'h0;
  endtask

  task automatic run_case(input int p, input int e, input int s,
                          input bit od, input bit rs, input bit sb);
    logic [31:0] w;
    bit clocked, gated, live, idle_req, wake_req;
    int lat, other;
    string tag;
    w = 32'hA5A5_0000;            // junk in ignored bits (R2)
    w[6:3] = 4'b1010;             // selector bits above SEL_W are ignored (R2)
    w[2:0] = 3'(s);
    w[9:8] = 2'(p);
    w[11:10] = 2'(e);
    w[14] = rs;
    w[15] = od;
    clocked  = (p < 2);
    gated    = sb && !rs;
    live     = clocked && !gated;
    idle_req = (p == 2) || (live && !od);
    wake_req = idle_req || (live && od);
    lat      = (p == 0) ? 2 : 3;
    other    = (s == GW - 1) ? 1 : s + 1;
    if (p == 3) tag = "R8";
    else if (p == 2) tag = "R7";
    else if (gated) tag = "R9";
    else if (e == 0) tag = "R6";
    else if (p == 0) tag = "R4";
    else tag = "R5";
    tag = $sformatf("%s p=%0d e=%0d s=%0d od=%0b rs=%0b sb=%0b", tag, p, e, s, od, rs, sb);

    gen = '0;
    stby = sb;
    write_cfg(w);
    for (int n = 0; n < 5; n++) begin
      step();
      chk(evt, 1'b0, {"R12 idle ", tag});
      chk(req, idle_req, {"R10 idle req ", tag});
    end
    // a neighbouring line must not reach the output (R2)
    gen[other] = 1'b1;
    for (int n = 0; n < 4; n++) begin
      step();
      chk(evt, 1'b0, {"R2 other line ", tag});
    end
    gen[other] = 1'b0;
    step();
    // rising change
    gen[s] = 1'b1;
    #1;
    if (p == 2) chk(evt, 1'b1, {"R7 pass ", tag});
    chk(req, wake_req, {"R11 wake ", tag});
    for (int n = 1; n <= 5; n++) begin
      step();
      chk(evt, (p == 2) || (live && (e == 1 || e == 3) && n == lat),
          {$sformatf("R6 rise n=%0d ", n), tag});
    end
    chk(req, idle_req, {"R11 settle ", tag});
    // falling change
    gen[s] = 1'b0;
    #1;
    if (p == 2) chk(evt, 1'b0, {"R7 pass ", tag});
    chk(req, wake_req, {"R11 wake ", tag});
    for (int n = 1; n <= 5; n++) begin
      step();
      chk(evt, live && (e == 2 || e == 3) && n == lat,
          {$sformatf("R6 fall n=%0d ", n), tag});
    end
    chk(req, idle_req, {"R11 settle ", tag});
    // rewrite while the chosen line is already high
    gen[s] = 1'b1;
    step();
    write_cfg(w);
    for (int n = 0; n < 6; n++) begin
      step();
      chk(evt, p == 2, {"R12 rewrite ", tag});
    end
  endtask

  initial begin
    repeat (3) step();
    chk(evt, 1'b0, "R1 reset evt");
    chk(req, 1'b0, "R1 reset req");
    rst_n = 1'b1;
    step();
    chk(evt, 1'b0, "R1 after release evt");
    chk(req, 1'b0, "R1 after release req");
    gen = '1;
    repeat (4) step();
    chk(evt, 1'b0, "R1 default selector evt");
    chk(req, 1'b0, "R1 default selector req");

    // selector zero on each route
    for (int p = 0; p < 4; p++) begin
      gen = '0;
      write_cfg({16'h0, 2'b01, 2'b00, 2'b11, 2'(p), 8'h00});
      for (int n = 0; n < GW; n++) begin
        gen = gen ^ GW'(n * 37 + 1);
        #1;
        chk(evt, 1'b0, $sformatf("R3 p=%0d evt", p));
        step();
        chk(evt, 1'b0, $sformatf("R3 p=%0d evt clk", p));
        chk(req, 1'b0, $sformatf("R3 p=%0d req", p));
      end
    end

    for (int sb = 0; sb < 2; sb++)
      for (int rs = 0; rs < 2; rs++)
        for (int od = 0; od < 2; od++)
          for (int p = 0; p < 4; p++)
            for (int e = 0; e < 4; e++)
              for (int s = 1; s < GW; s++)
                run_case(p, e, s, od[0], rs[0], sb[0]);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule